// File: doc/BRIEF.md
# Load/Store Queue with In-Order Commit

This block sits between an in-order issue stage and a data cache. It takes one memory micro-operation per cycle: a load, a store or a synchronising barrier. Each one carries a base address, a signed offset, an access size, store data and a completion tag. The block forms the effective address, places data in the correct byte lanes and sends word-wide requests to a cache port. That port has a fixed one-cycle read latency.

Loads are sent to the cache at once, unless they touch bytes held by an older queued store. Their aligned, zero-extended result is parked in a rename slot. It reaches the retire port only when the completion logic pulses commit with that load's tag. Stores wait in a FIFO and are written to the cache only after their tag has been committed, so nothing speculative ever reaches memory. Loads therefore overtake stores that do not conflict with them.

A flush discards every store and load result that has not been committed. A barrier holds the issue port until all older memory traffic has finished.

Top module: `lsq_commit`

## Requirements
- R1: After reset no cache request and no retire is signalled, and a load is accepted (issue_ready_o high).
- R2: An accepted load (op 0) drives a read request in the next cycle. The request has creq_we_o low and word address (base + sign-extended offset) >> 2. Size codes: 0 byte, 1 halfword, 2 word.
- R3: Load data appears on the retire port, with its tag, exactly one cycle after the commit pulse for that tag, and never before it. Byte and halfword results are taken from the lane selected by the low address bits and zero-extended.
- R4: A store (op 1) is never written before its tag is committed. If it is committed in the cycle after issue, its write request appears three cycles after issue.
- R5: The byte enables are 0001, 0011 or 1111 for byte, halfword or word, shifted left by address bits [1:0]. Store data is shifted left by 8 times that amount.
- R6: A load whose enabled bytes overlap no queued store is accepted without stall and is requested ahead of those stores.
- R7: A load that shares an enabled byte with a queued store is held (issue_ready_o low) until that store has been written, and then it returns the stored bytes.
- R8: When a load is accepted in the same cycle that a committed store could drain, the load request goes out first and the store follows one cycle later.
- R9: A barrier (op 2 or 3) is accepted only once the store queue is empty and no load is awaiting data. No younger operation is accepted before it.
- R10: A flush drops uncommitted stores, which are never written, and all pending load results, whose later commit produces no retire. A store committed in the same cycle as the flush is still written.
- R11: A store is refused while SQ_DEPTH stores are queued. A load is refused while RN_SLOTS results are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Operation offered |
| issue_ready_o | output | 1 | Operation accepted this cycle |
| issue_op_i | input | 2 | 0 load, 1 store, 2/3 barrier |
| issue_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| issue_base_i | input | 32 | Base address |
| issue_offs_i | input | OFFS_W | Signed displacement |
| issue_wdata_i | input | 32 | Store data, right-aligned |
| issue_tag_i | input | 4 | Completion tag |
| commit_valid_i | input | 1 | Commit pulse |
| commit_tag_i | input | 4 | Tag being committed |
| flush_i | input | 1 | Discard uncommitted work |
| creq_valid_o | output | 1 | Cache request |
| creq_we_o | output | 1 | Request is a write |
| creq_waddr_o | output | 30 | Word address |
| creq_be_o | output | 4 | Byte enables |
| creq_wdata_o | output | 32 | Lane-aligned write data |
| cache_rdata_i | input | 32 | Read word, one cycle after a read request |
| retire_valid_o | output | 1 | Load result committed |
| retire_tag_o | output | 4 | Tag of the committed load |
| retire_data_o | output | 32 | Zero-extended load result |

## Verification
Several properties are checked on every cycle. The store queue never overfills and only pops a committed head. A flush never grows the queue. Every request carries non-zero byte enables. An accepted load always yields a read request on the next cycle. A retire always follows a commit pulse, and allocation never takes a slot when none is free.

Other behaviour only the bench scenarios can show. These are the exact write latency, the load-over-drain ordering, the stalls caused by conflicts and barriers, and the data returned after a flush. Lane placement and zero extension are also bench-only, and they are compared with a reference memory over random sizes and offsets.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned NBYTE = XLEN / 8;
  localparam int unsigned WA_W  = XLEN - 2;
  localparam int unsigned TAG_W = 4;

  typedef struct packed {
    logic [WA_W-1:0]  waddr;
    logic [NBYTE-1:0] be;
    logic [XLEN-1:0]  data;
    logic [TAG_W-1:0] tag;
  } st_ent_t;

  function automatic logic [NBYTE-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 4'b0001;
      2'd1:    size_mask = 4'b0011;
      default: size_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/lsq_agen.sv
module lsq_agen
  import lsq_pkg::*;
#(
  parameter int unsigned OFFS_W = 16
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic [OFFS_W-1:0] offs_i,
  input  logic [1:0]        size_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [WA_W-1:0]   waddr_o,
  output logic [1:0]        lane_o,
  output logic [NBYTE-1:0]  be_o,
  output logic [XLEN-1:0]   wlane_o
);
  logic [XLEN-1:0] offs_x, ea;

  assign offs_x  = {{(XLEN-OFFS_W){offs_i[OFFS_W-1]}}, offs_i};
  assign ea      = base_i + offs_x;
  assign waddr_o = ea[XLEN-1:2];
  assign lane_o  = ea[1:0];
  assign be_o    = size_mask(size_i) << ea[1:0];
  assign wlane_o = wdata_i << {ea[1:0], 3'b000};
endmodule

// File: rtl/lsq_ldext.sv
module lsq_ldext
  import lsq_pkg::*;
(
  input  logic [XLEN-1:0] rdata_i,
  input  logic [1:0]      lane_i,
  input  logic [1:0]      size_i,
  output logic [XLEN-1:0] data_o
);
  logic [XLEN-1:0] sh;

  assign sh = rdata_i >> {lane_i, 3'b000};

  always_comb begin
    case (size_i)
      2'd0:    data_o = {{(XLEN-8){1'b0}}, sh[7:0]};
      2'd1:    data_o = {{(XLEN-16){1'b0}}, sh[15:0]};
      default: data_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/lsq_store_q.sv
module lsq_store_q
  import lsq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  st_ent_t          push_ent_i,
  input  logic             pop_i,
  input  logic             commit_valid_i,
  input  logic [TAG_W-1:0] commit_tag_i,
  input  logic             flush_i,
  input  logic [WA_W-1:0]  probe_waddr_i,
  input  logic [NBYTE-1:0] probe_be_i,
  output logic             hit_o,
  output st_ent_t          head_o,
  output logic             head_ready_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  st_ent_t          ent_q [DEPTH];
  logic [DEPTH-1:0] cmt_q, cmt_nxt, vld;
  logic [PW-1:0]    head_q, tail;
  logic [CW-1:0]    cnt_q, kept;

  assign tail    = head_q + PW'(cnt_q);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = ent_q[head_q];

  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      vld[i]     = CW'(PW'(PW'(i) - head_q)) < cnt_q;
      cmt_nxt[i] = cmt_q[i] | (commit_valid_i && vld[i] && ent_q[i].tag == commit_tag_i);
      if (vld[i] && ent_q[i].waddr == probe_waddr_i && |(ent_q[i].be & probe_be_i))
        hit_o = 1'b1;
    end
  end

  // commits arrive in order, so committed entries form a prefix from head
  assign kept         = CW'($countones(cmt_nxt & vld));
  assign head_ready_o = vld[head_q] && cmt_q[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
      cmt_q  <= '0;
    end else begin
      cmt_q <= cmt_nxt;
      if (push_i) cmt_q[tail] <= 1'b0;
      if (pop_i)  head_q <= head_q + 1'b1;
      if (flush_i) cnt_q <= kept - CW'(pop_i);
      else         cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) ent_q[tail] <= push_ent_i;
  end

  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r4_pop_committed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (vld[head_q] && cmt_q[head_q]));
  a_r10_flush_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/lsq_rename.sv
module lsq_rename
  import lsq_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  output logic [$clog2(SLOTS)-1:0] alloc_idx_o,
  output logic             free_o,
  input  logic             fill_i,
  input  logic [$clog2(SLOTS)-1:0] fill_idx_i,
  input  logic [XLEN-1:0]  fill_data_i,
  input  logic             commit_valid_i,
  input  logic [TAG_W-1:0] commit_tag_i,
  input  logic             flush_i,
  output logic             retire_valid_o,
  output logic [TAG_W-1:0] retire_tag_o,
  output logic [XLEN-1:0]  retire_data_o
);
  localparam int unsigned IW = $clog2(SLOTS);

  logic [SLOTS-1:0] vld_q, fil_q;
  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [XLEN-1:0]  dat_q [SLOTS];
  logic             hit;
  logic [IW-1:0]    hit_idx;

  assign free_o = ~&vld_q;

  always_comb begin
    alloc_idx_o = '0;
    hit         = 1'b0;
    hit_idx     = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!vld_q[i]) alloc_idx_o = IW'(i);
      if (vld_q[i] && fil_q[i] && tag_q[i] == commit_tag_i) begin
        hit     = commit_valid_i;
        hit_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q          <= '0;
      fil_q          <= '0;
      retire_valid_o <= 1'b0;
      retire_tag_o   <= '0;
      retire_data_o  <= '0;
    end else begin
      retire_valid_o <= hit;
      retire_tag_o   <= commit_tag_i;
      retire_data_o  <= dat_q[hit_idx];
      if (hit) vld_q[hit_idx] <= 1'b0;
      if (alloc_i) begin
        vld_q[alloc_idx_o] <= 1'b1;
        fil_q[alloc_idx_o] <= 1'b0;
      end
      if (fill_i) fil_q[fill_idx_i] <= 1'b1;
      if (flush_i) vld_q <= '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) tag_q[alloc_idx_o] <= alloc_tag_i;
    if (fill_i)  dat_q[fill_idx_i]  <= fill_data_i;
  end

  a_r3_retire_after_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_o |-> $past(commit_valid_i));
  a_r11_alloc_has_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !vld_q[alloc_idx_o]);
endmodule

// File: rtl/lsq_commit.sv
module lsq_commit
  import lsq_pkg::*;
#(
  parameter int unsigned SQ_DEPTH = 4,
  parameter int unsigned RN_SLOTS = 4,
  parameter int unsigned OFFS_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  output logic              issue_ready_o,
  input  logic [1:0]        issue_op_i,
  input  logic [1:0]        issue_size_i,
  input  logic [XLEN-1:0]   issue_base_i,
  input  logic [OFFS_W-1:0] issue_offs_i,
  input  logic [XLEN-1:0]   issue_wdata_i,
  input  logic [TAG_W-1:0]  issue_tag_i,
  input  logic              commit_valid_i,
  input  logic [TAG_W-1:0]  commit_tag_i,
  input  logic              flush_i,
  output logic              creq_valid_o,
  output logic              creq_we_o,
  output logic [WA_W-1:0]   creq_waddr_o,
  output logic [NBYTE-1:0]  creq_be_o,
  output logic [XLEN-1:0]   creq_wdata_o,
  input  logic [XLEN-1:0]   cache_rdata_i,
  output logic              retire_valid_o,
  output logic [TAG_W-1:0]  retire_tag_o,
  output logic [XLEN-1:0]   retire_data_o
);
  localparam int unsigned IW = $clog2(RN_SLOTS);

  typedef struct packed {
    logic          v;
    logic [IW-1:0] idx;
    logic [1:0]    lane;
    logic [1:0]    size;
  } ld_pipe_t;

  logic [WA_W-1:0]  ag_waddr;
  logic [1:0]       ag_lane;
  logic [NBYTE-1:0] ag_be;
  logic [XLEN-1:0]  ag_wlane, ld_data;
  logic             is_ld, is_st, is_sync, ld_busy;
  logic             sq_hit, sq_head_rdy, sq_full, sq_empty, sq_pop;
  logic             rn_free, ld_acc, st_acc;
  logic [IW-1:0]    rn_idx;
  st_ent_t          sq_head;
  ld_pipe_t         ld1_q, ld2_q;

  lsq_agen #(.OFFS_W(OFFS_W)) u_agen (
    .base_i (issue_base_i), .offs_i (issue_offs_i), .size_i (issue_size_i),
    .wdata_i(issue_wdata_i), .waddr_o(ag_waddr), .lane_o (ag_lane),
    .be_o   (ag_be), .wlane_o(ag_wlane)
  );

  assign is_ld   = (issue_op_i == 2'd0);
  assign is_st   = (issue_op_i == 2'd1);
  assign is_sync = issue_op_i[1];
  assign ld_busy = ld1_q.v | ld2_q.v;

  always_comb begin
    if (flush_i)      issue_ready_o = 1'b0;
    else if (is_sync) issue_ready_o = sq_empty && !ld_busy;
    else if (is_st)   issue_ready_o = !sq_full;
    else              issue_ready_o = rn_free && !sq_hit;
  end

  assign ld_acc = issue_valid_i && issue_ready_o && is_ld;
  assign st_acc = issue_valid_i && issue_ready_o && is_st;
  assign sq_pop = sq_head_rdy && !ld_acc;  // loads win the cache port

  lsq_store_q #(.DEPTH(SQ_DEPTH)) u_sq (
    .clk_i, .rst_ni,
    .push_i        (st_acc),
    .push_ent_i    ('{waddr: ag_waddr, be: ag_be, data: ag_wlane, tag: issue_tag_i}),
    .pop_i         (sq_pop),
    .commit_valid_i, .commit_tag_i, .flush_i,
    .probe_waddr_i (ag_waddr),
    .probe_be_i    (ag_be),
    .hit_o         (sq_hit),
    .head_o        (sq_head),
    .head_ready_o  (sq_head_rdy),
    .full_o        (sq_full),
    .empty_o       (sq_empty)
  );

  lsq_ldext u_ldext (
    .rdata_i(cache_rdata_i), .lane_i(ld2_q.lane), .size_i(ld2_q.size), .data_o(ld_data)
  );

  lsq_rename #(.SLOTS(RN_SLOTS)) u_rn (
    .clk_i, .rst_ni,
    .alloc_i       (ld_acc),
    .alloc_tag_i   (issue_tag_i),
    .alloc_idx_o   (rn_idx),
    .free_o        (rn_free),
    .fill_i        (ld2_q.v),
    .fill_idx_i    (ld2_q.idx),
    .fill_data_i   (ld_data),
    .commit_valid_i, .commit_tag_i, .flush_i,
    .retire_valid_o, .retire_tag_o, .retire_data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      creq_valid_o <= 1'b0;
      creq_we_o    <= 1'b0;
      creq_waddr_o <= '0;
      creq_be_o    <= '0;
      creq_wdata_o <= '0;
      ld1_q        <= '0;
      ld2_q        <= '0;
    end else begin
      creq_valid_o <= ld_acc | sq_pop;
      if (ld_acc) begin
        creq_we_o    <= 1'b0;
        creq_waddr_o <= ag_waddr;
        creq_be_o    <= ag_be;
        creq_wdata_o <= '0;
      end else if (sq_pop) begin
        creq_we_o    <= 1'b1;
        creq_waddr_o <= sq_head.waddr;
        creq_be_o    <= sq_head.be;
        creq_wdata_o <= sq_head.data;
      end
      ld1_q <= '{v: ld_acc, idx: rn_idx, lane: ag_lane, size: issue_size_i};
      ld2_q <= ld1_q;
      if (flush_i) begin
        ld1_q.v <= 1'b0;
        ld2_q.v <= 1'b0;
      end
    end
  end

  a_r2_load_request_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_acc |=> (creq_valid_o && !creq_we_o));
  a_r5_be_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    creq_valid_o |-> (creq_be_o != '0));
endmodule

// File: tb/lsq_commit_test.sv
`timescale 1ns/1ps
module lsq_commit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0, issue_ready;
  logic [1:0]  issue_op = 2'd0, issue_size = 2'd0;
  logic [31:0] issue_base = 32'h100, issue_wdata = '0;
  logic [15:0] issue_offs = '0;
  logic [3:0]  issue_tag = '0;
  logic        commit_valid = 1'b0, flush = 1'b0;
  logic [3:0]  commit_tag = '0;
  logic        creq_valid, creq_we;
  logic [29:0] creq_waddr;
  logic [3:0]  creq_be;
  logic [31:0] creq_wdata, cache_rdata;
  logic        ret_v;
  logic [3:0]  ret_tag;
  logic [31:0] ret_data;

  always #2.5 clk = ~clk;

  lsq_commit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(issue_valid), .issue_ready_o(issue_ready), .issue_op_i(issue_op),
    .issue_size_i(issue_size), .issue_base_i(issue_base), .issue_offs_i(issue_offs),
    .issue_wdata_i(issue_wdata), .issue_tag_i(issue_tag),
    .commit_valid_i(commit_valid), .commit_tag_i(commit_tag), .flush_i(flush),
    .creq_valid_o(creq_valid), .creq_we_o(creq_we), .creq_waddr_o(creq_waddr),
    .creq_be_o(creq_be), .creq_wdata_o(creq_wdata), .cache_rdata_i(cache_rdata),
    .retire_valid_o(ret_v), .retire_tag_o(ret_tag), .retire_data_o(ret_data)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int wr_cnt = 0, rd_cnt = 0, last_wr_cyc = 0, last_rd_cyc = 0;
  logic [29:0] last_wr_addr = '0, last_rd_addr = '0;
  logic [3:0]  last_wr_be = '0, last_rd_be = '0;
  logic [31:0] last_wr_data = '0;
  logic [31:0] mem  [16];
  logic [31:0] refm [16];

  always @(posedge clk) cyc <= cyc + 1;

  // cache model: one-cycle read latency, byte-enabled writes
  always @(posedge clk) begin
    if (creq_valid) begin
      if (creq_we) begin
        for (int b = 0; b < 4; b++)
          if (creq_be[b]) mem[creq_waddr[3:0]][8*b +: 8] <= creq_wdata[8*b +: 8];
        wr_cnt <= wr_cnt + 1; last_wr_cyc <= cyc; last_wr_addr <= creq_waddr;
        last_wr_be <= creq_be; last_wr_data <= creq_wdata;
      end else begin
        cache_rdata <= mem[creq_waddr[3:0]];
        rd_cnt <= rd_cnt + 1; last_rd_cyc <= cyc; last_rd_addr <= creq_waddr;
        last_rd_be <= creq_be;
      end
    end
  end

  function automatic logic [3:0] be_of(input logic [1:0] sz, input logic [1:0] lane);
    logic [3:0] m;
    m = (sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111;
    return m << lane;
  endfunction

  function automatic logic [31:0] ld_exp(input logic [31:0] w, input logic [1:0] lane,
                                         input logic [1:0] sz);
    logic [31:0] s;
    s = w >> (8 * lane);
    if (sz == 2'd0) return {24'h0, s[7:0]};
    if (sz == 2'd1) return {16'h0, s[15:0]};
    return w;
  endfunction

  task automatic ref_store(input int w, input logic [1:0] lane, input logic [1:0] sz,
                           input logic [31:0] d);
    logic [3:0]  m;
    logic [31:0] sh;
    m  = be_of(sz, lane);
    sh = d << (8 * lane);
    for (int b = 0; b < 4; b++) if (m[b]) refm[w][8*b +: 8] = sh[8*b +: 8];
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic do_issue(input logic [1:0] op, input logic [1:0] sz, input int w,
                          input logic [1:0] lane, input logic [31:0] d,
                          input logic [3:0] tag, output int acc);
    issue_op = op; issue_size = sz; issue_offs = 16'(4 * w + lane);
    issue_wdata = d; issue_tag = tag; issue_valid = 1'b1;
    #1;
    while (!issue_ready) begin @(negedge clk); #1; end
    acc = cyc;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic do_commit(input logic [3:0] tag);
    commit_valid = 1'b1; commit_tag = tag;
    @(negedge clk);
    commit_valid = 1'b0;
  endtask

  task automatic load_check(input string req, input logic [3:0] tag, input logic [31:0] exp);
    do_commit(tag);
    chk({req, " retire valid"}, 32'(ret_v), 32'd1);
    chk({req, " retire tag"}, 32'(ret_tag), 32'(tag));
    chk({req, " retire data"}, ret_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int acc, st, w0, hi;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) begin
      mem[i]  = 32'h0F1E2D3C ^ (32'h01010101 * i);
      refm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ready", 32'(issue_ready), 32'd1);
    chk("R1 no request", 32'(creq_valid), 32'd0);
    chk("R1 no retire", 32'(ret_v), 32'd0);

    // R2 / R3: word load, request timing and address
    do_issue(2'd0, 2'd2, 2, 2'd0, 0, 4'd1, acc);
    repeat (3) @(negedge clk);
    chk("R2 read cycle", 32'(last_rd_cyc), 32'(acc + 1));
    chk("R2 read addr", 32'(last_rd_addr), 32'h40 + 2);
    chk("R2 read be", 32'(last_rd_be), 32'hF);
    chk("R3 held before commit", 32'(ret_v), 32'd0);
    load_check("R3 word", 4'd1, refm[2]);
    do_issue(2'd0, 2'd0, 2, 2'd3, 0, 4'd2, acc);
    repeat (3) @(negedge clk);
    load_check("R3 byte lane3", 4'd2, ld_exp(refm[2], 2'd3, 2'd0));
    do_issue(2'd0, 2'd1, 2, 2'd2, 0, 4'd3, acc);
    hi = 0;
    repeat (6) begin @(negedge clk); hi += int'(ret_v); end
    chk("R3 no retire without commit", 32'(hi), 32'd0);
    load_check("R3 half lane2", 4'd3, ld_exp(refm[2], 2'd2, 2'd1));

    // R4 / R5: store held until commit
    w0 = wr_cnt;
    do_issue(2'd1, 2'd0, 1, 2'd1, 32'hEE, 4'd4, acc);
    ref_store(1, 2'd1, 2'd0, 32'hEE);
    repeat (6) @(negedge clk);
    chk("R4 no write before commit", 32'(wr_cnt - w0), 32'd0);
    do_commit(4'd4);
    repeat (4) @(negedge clk);
    chk("R4 write after commit", 32'(wr_cnt - w0), 32'd1);
    chk("R5 byte be", 32'(last_wr_be), 32'b0010);
    chk("R5 byte lane data", 32'(last_wr_data[15:8]), 32'hEE);
    do_issue(2'd1, 2'd1, 3, 2'd2, 32'hBEEF, 4'd5, acc);
    ref_store(3, 2'd2, 2'd1, 32'hBEEF);
    do_commit(4'd5);
    repeat (4) @(negedge clk);
    chk("R4 three-cycle latency", 32'(last_wr_cyc), 32'(acc + 3));
    chk("R5 half be", 32'(last_wr_be), 32'b1100);
    chk("R5 half lane data", 32'(last_wr_data[31:16]), 32'hBEEF);
    chk("R5 word addr", 32'(last_wr_addr), 32'h43);

    // R6: bypass of non-overlapping stores
    w0 = wr_cnt;
    do_issue(2'd1, 2'd2, 4, 2'd0, 32'h12345678, 4'd6, acc);
    st = cyc;
    do_issue(2'd0, 2'd2, 5, 2'd0, 0, 4'd7, acc);
    chk("R6 word load not stalled", 32'(acc), 32'(st));
    do_issue(2'd1, 2'd0, 6, 2'd0, 32'h99, 4'd8, acc);
    st = cyc;
    do_issue(2'd0, 2'd0, 6, 2'd1, 0, 4'd9, acc);
    chk("R6 adjacent byte not stalled", 32'(acc), 32'(st));
    repeat (3) @(negedge clk);
    chk("R6 loads ahead of stores", 32'(wr_cnt - w0), 32'd0);
    do_commit(4'd6);
    ref_store(4, 2'd0, 2'd2, 32'h12345678);
    load_check("R6 word", 4'd7, refm[5]);
    do_commit(4'd8);
    ref_store(6, 2'd0, 2'd0, 32'h99);
    load_check("R6 byte", 4'd9, ld_exp(refm[6], 2'd1, 2'd0));

    // R7: overlapping load stalls
    do_issue(2'd1, 2'd1, 7, 2'd0, 32'hCAFE, 4'd10, acc);
    ref_store(7, 2'd0, 2'd1, 32'hCAFE);
    issue_op = 2'd0; issue_size = 2'd2; issue_offs = 16'd28; issue_tag = 4'd11;
    issue_valid = 1'b1;
    #1 chk("R7 stalled", 32'(issue_ready), 32'd0);
    repeat (3) @(negedge clk);
    #1 chk("R7 still stalled", 32'(issue_ready), 32'd0);
    @(negedge clk);
    issue_valid = 1'b0;
    do_commit(4'd10);
    repeat (4) @(negedge clk);
    do_issue(2'd0, 2'd2, 7, 2'd0, 0, 4'd11, acc);
    repeat (3) @(negedge clk);
    load_check("R7 forwarded data", 4'd11, refm[7]);

    // R8: load beats committed store drain
    do_issue(2'd1, 2'd2, 8, 2'd0, 32'hA1B2C3D4, 4'd12, st);
    ref_store(8, 2'd0, 2'd2, 32'hA1B2C3D4);
    commit_valid = 1'b1; commit_tag = 4'd12;
    @(negedge clk);
    commit_valid = 1'b0;
    do_issue(2'd0, 2'd2, 9, 2'd0, 0, 4'd13, acc);
    repeat (3) @(negedge clk);
    chk("R8 read first", 32'(last_rd_cyc), 32'(st + 3));
    chk("R8 write after", 32'(last_wr_cyc), 32'(st + 4));
    load_check("R8 data", 4'd13, refm[9]);

    // R9: barrier
    w0 = wr_cnt;
    do_issue(2'd1, 2'd2, 10, 2'd0, 32'h5555AAAA, 4'd14, acc);
    ref_store(10, 2'd0, 2'd2, 32'h5555AAAA);
    issue_op = 2'd2; issue_valid = 1'b1;
    #1 chk("R9 barrier waits for store", 32'(issue_ready), 32'd0);
    @(negedge clk);
    commit_valid = 1'b1; commit_tag = 4'd14;
    @(negedge clk);
    commit_valid = 1'b0;
    #1;
    while (!issue_ready) begin @(negedge clk); #1; end
    st = cyc;
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R9 store done before barrier", 32'(wr_cnt - w0), 32'd1);
    chk("R9 write not after barrier", 32'(last_wr_cyc <= st), 32'd1);
    do_issue(2'd0, 2'd2, 11, 2'd0, 0, 4'd15, acc);
    do_issue(2'd2, 2'd0, 0, 2'd0, 0, 4'd0, st);
    chk("R9 barrier waits for load", 32'(st), 32'(acc + 3));
    load_check("R9 load", 4'd15, refm[11]);

    // R10: flush
    w0 = wr_cnt;
    do_issue(2'd1, 2'd2, 11, 2'd0, 32'h11111111, 4'd0, acc);
    do_issue(2'd1, 2'd2, 12, 2'd0, 32'h22222222, 4'd1, acc);
    do_issue(2'd0, 2'd2, 13, 2'd0, 0, 4'd2, acc);
    ref_store(11, 2'd0, 2'd2, 32'h11111111);
    repeat (4) @(negedge clk);
    commit_valid = 1'b1; commit_tag = 4'd0; flush = 1'b1;
    @(negedge clk);
    commit_valid = 1'b0; flush = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 committed store kept", 32'(wr_cnt - w0), 32'd1);
    chk("R10 kept store addr", 32'(last_wr_addr), 32'h40 + 11);
    do_commit(4'd1);
    repeat (5) @(negedge clk);
    chk("R10 flushed store dropped", 32'(wr_cnt - w0), 32'd1);
    do_commit(4'd2);
    chk("R10 flushed load no retire", 32'(ret_v), 32'd0);

    // R11: capacity limits
    w0 = wr_cnt;
    for (int k = 0; k < 4; k++) begin
      do_issue(2'd1, 2'd2, k, 2'd0, 32'hC0DE0000 + k, 4'(3 + k), acc);
      ref_store(k, 2'd0, 2'd2, 32'hC0DE0000 + k);
    end
    issue_op = 2'd1; issue_valid = 1'b1;
    #1 chk("R11 store queue full", 32'(issue_ready), 32'd0);
    @(negedge clk);
    issue_valid = 1'b0;
    for (int k = 0; k < 4; k++) do_commit(4'(3 + k));
    repeat (6) @(negedge clk);
    chk("R11 all stores drained", 32'(wr_cnt - w0), 32'd4);
    for (int k = 0; k < 4; k++) do_issue(2'd0, 2'd2, k, 2'd0, 0, 4'(7 + k), acc);
    issue_op = 2'd0; issue_offs = 16'd60; issue_valid = 1'b1;
    #1 chk("R11 rename full", 32'(issue_ready), 32'd0);
    @(negedge clk);
    issue_valid = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 4; k++) load_check("R11 pending load", 4'(7 + k), refm[k]);

    // random stores and loads against the reference memory (R3, R5)
    for (int it = 0; it < 60; it++) begin
      int w;
      logic [1:0] sz, ln;
      logic [31:0] d;
      w  = int'($urandom % 16);
      sz = 2'($urandom % 3);
      ln = (sz == 2'd0) ? 2'($urandom % 4) : (sz == 2'd1) ? {1'($urandom % 2), 1'b0} : 2'd0;
      d  = $urandom;
      do_issue(2'd1, sz, w, ln, d, 4'd12, acc);
      ref_store(w, ln, sz, d);
      do_commit(4'd12);
      repeat (3) @(negedge clk);
      w  = int'($urandom % 16);
      sz = 2'($urandom % 3);
      ln = (sz == 2'd0) ? 2'($urandom % 4) : (sz == 2'd1) ? {1'($urandom % 2), 1'b0} : 2'd0;
      do_issue(2'd0, sz, w, ln, 0, 4'd13, acc);
      repeat (2) @(negedge clk);
      load_check("R3 R5 random", 4'd13, ld_exp(refm[w], ln, sz));
    end
    finish_run();
  end
endmodule